// File: doc/BRIEF.md
# Register-Mapped EDID Read Controller

This block gives host software a four-register view of a display-bus controller, but no bus wires are driven. Display identification bytes come from an internal 128-entry table. Software uses the normal sequence for this kind of controller. It first chooses a port, then writes a command that names the target device, the byte count, an optional start index and a cycle type. It then drains the data register, which yields up to four table bytes on each read.

Inside the block, a small phase machine tracks the transfer through idle, data and wait. It keeps a read pointer and a byte count, and it keeps status flags that software polls. A per-port monitor-present input decides whether identification data exists behind the chosen port. Register reads return their data one cycle after the request, and the value is held until the next read.

Top module: `edid_reg_ctl`

## Requirements
- R1: After reset the status register reads 0x06: hardware-ready (bit 2) and target-error (bit 1) are set, and the phase field (bits 7:6, with idle=0, data=1, wait=2) is idle. Command and data read as 0. The other status bits are active (bit 0), wait flag (bit 3) and in-use (bit 4).
- R2: Register offsets are 0 for pin select, 1 for command, 2 for status and 3 for data. A pin-select value p from 1 to 4 picks port p-1. It sets phase idle, clears active, and sets hardware-ready and the wait flag. Target-error is cleared if that port's monitor is present and set otherwise. Any pin-select write resets the selection, the pointer and the count. Pin values 0 and 5 to 7 leave the status unchanged.
- R3: The command fields are: direction in bit 0 (1 = read), target address in bits 7:1, start index in bits 15:8, byte count in bits 24:16 and cycle type in bits 27:25. In the cycle type, bit 25 marks a transfer, bit 26 marks an indexed transfer and bit 27 marks a stop. The start index is loaded into the pointer only when bit 26 is set.
- R4: Only target address 0x50 selects the identification device. Reads after any other address return zero bytes.
- R5: A data read with read direction set and left = count - pointer > 0 returns min(4, left) bytes, packed least-significant first, with the upper bytes zero. The pointer then advances by that many bytes. Table byte k holds (29*k + 60) mod 256. Indices of 128 and above, no selection, or no monitor give 0.
- R6: A data read with read direction clear, or with no bytes left, returns the last data word again.
- R7: A read that takes the final bytes clears active and resets selection, pointer and count. It sets phase idle if the stored cycle has the stop bit, and wait otherwise.
- R8: A command with the transfer bit set sets phase data and active. Cycle type 4 (stop alone) resets the EDID state, sets idle and clears active, but only if the stored cycle type was nonzero. Cycle types 0, 2 and 6 do not change the phase.
- R9: A status read returns the current value and then sets in-use. Writing 1 to bit 4 of the status register clears in-use. All other status bits ignore writes.
- R10: A command with bit 31 set, written while bit 31 is stored clear, sets hardware-ready. While bit 31 is stored set, writes with bit 31 set are ignored. A write with bit 31 clear then clears it and resets the status to hardware-ready, plus target-error if no identification data is available, with phase idle.
- R11: The stored command reads back with bit 30 always 0.
- R12: Read data appears on the data output the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| monitor_present | input | 4 | One bit per port: monitor with identification data attached |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, one cycle after host_rd |

## Verification
The assertions assume that host_wr and host_rd are never high in the same cycle, and that monitor_present changes only between transfers. The bench drives every access through tasks that raise a single strobe for exactly one cycle, and it holds monitor_present constant for the whole run. The sweep covers start indices near both ends of the table, lengths that end on and off a four-byte boundary, and both stop and no-stop completion.

// File: rtl/edid_ctl_pkg.sv
package edid_ctl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    // register offsets
    localparam logic [1:0] OFS_PIN    = 2'd0;
    localparam logic [1:0] OFS_CMD    = 2'd1;
    localparam logic [1:0] OFS_STATUS = 2'd2;
    localparam logic [1:0] OFS_DATA   = 2'd3;

    // command fields
    localparam int CMD_DIR     = 0;
    localparam int CMD_ADDR_LO = 1;
    localparam int CMD_IDX_LO  = 8;
    localparam int CMD_CNT_LO  = 16;
    localparam int CMD_CNT_W   = 9;
    localparam int CMD_CYC_LO  = 25;
    localparam int CMD_SWRDY   = 30;
    localparam int CMD_SWCLR   = 31;

    // status bits
    localparam int ST_ACTIVE = 0;
    localparam int ST_TERR   = 1;
    localparam int ST_HWRDY  = 2;
    localparam int ST_WAITF  = 3;
    localparam int ST_INUSE  = 4;

    function automatic logic [7:0] table_byte(input logic [15:0] idx,
                                              input logic [7:0]  step,
                                              input logic [7:0]  seed);
        return 8'(idx * 16'(step) + 16'(seed));
    endfunction

endpackage

// File: rtl/edid_pin_map.sv
module edid_pin_map #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 2
) (
    input  logic [2:0]        pin,
    output logic              hit,
    output logic [PORT_W-1:0] port
);
    assign hit  = (pin != 3'd0) && (int'(pin) <= NUM_PORTS);
    assign port = PORT_W'(pin - 3'd1);
endmodule

// File: rtl/edid_pack_lanes.sv
module edid_pack_lanes
    import edid_ctl_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int TABLE_BYTES = 128,
    parameter int PTR_W       = 10,
    parameter int LANE_W      = 3,
    parameter int STEP        = 29,
    parameter int SEED        = 60
) (
    input  logic [PTR_W-1:0]     ptr,
    input  logic [LANE_W-1:0]    n,
    input  logic                 allow,
    output logic [8*LANES-1:0]   word
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [PTR_W:0] idx;
        logic           take;
        assign idx  = {1'b0, ptr} + (PTR_W+1)'(i);
        assign take = allow && (LANE_W'(i) < n) && (idx < (PTR_W+1)'(TABLE_BYTES));
        assign word[8*i +: 8] = take ? table_byte(16'(idx), 8'(STEP), 8'(SEED)) : 8'h00;
    end
endmodule

// File: rtl/edid_reg_ctl.sv
module edid_reg_ctl
    import edid_ctl_pkg::*;
#(
    parameter int          NUM_PORTS   = 4,
    parameter int          TABLE_BYTES = 128,
    parameter int          LANES       = 4,
    parameter logic [6:0]  EDID_ADDR   = 7'h50,
    parameter int          TABLE_STEP  = 29,
    parameter int          TABLE_SEED  = 60
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] monitor_present,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [1:0]           host_addr,
    input  logic [31:0]          host_wdata,
    output logic [31:0]          host_rdata
);
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int PTR_W  = CMD_CNT_W + 1;
    localparam int LANE_W = $clog2(LANES + 1);
    localparam int WORD_W = 8 * LANES;

    typedef struct packed {
        logic [2:0]        pin;
        logic [31:0]       cmd;
        logic              active;
        logic              terr;
        logic              hwrdy;
        logic              waitf;
        logic              inuse;
        phase_e            phase;
        logic              sel;
        logic              avail;
        logic [PORT_W-1:0] port;
        logic [PTR_W-1:0]  ptr;
        logic [CMD_CNT_W-1:0] count;
        logic [31:0]       data;
        logic [31:0]       rdata;
    } state_t;

    state_t state_d, state_q;

    // pin decode of the incoming write value
    logic              pin_hit;
    logic [PORT_W-1:0] pin_port;

    edid_pin_map #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_pin_map (
        .pin (host_wdata[2:0]),
        .hit (pin_hit),
        .port(pin_port)
    );

    // bytes still owed to the host
    logic signed [11:0] left;
    logic [LANE_W-1:0]  take_n;
    logic               bytes_ok;
    logic [WORD_W-1:0]  packed_word;

    assign left     = $signed({3'b0, state_q.count}) - $signed({2'b0, state_q.ptr});
    assign take_n   = (int'(left) >= LANES) ? LANE_W'(LANES) : LANE_W'(left);
    assign bytes_ok = state_q.sel && state_q.avail && monitor_present[state_q.port];

    edid_pack_lanes #(
        .LANES(LANES), .TABLE_BYTES(TABLE_BYTES), .PTR_W(PTR_W),
        .LANE_W(LANE_W), .STEP(TABLE_STEP), .SEED(TABLE_SEED)
    ) u_pack (
        .ptr  (state_q.ptr),
        .n    (take_n),
        .allow(bytes_ok),
        .word (packed_word)
    );

    logic [31:0] status_word;
    assign status_word = {24'b0, state_q.phase, 1'b0, state_q.inuse, state_q.waitf,
                          state_q.hwrdy, state_q.terr, state_q.active};

    logic [31:0] wv;
    logic [2:0]  new_cyc;
    logic [2:0]  old_cyc;
    assign old_cyc = state_q.cmd[CMD_CYC_LO +: 3];

    always_comb begin
        state_d = state_q;
        wv      = host_wdata;
        wv[CMD_SWRDY] = 1'b0;
        new_cyc = wv[CMD_CYC_LO +: 3];

        if (host_wr) begin
            unique case (host_addr)
                OFS_PIN: begin
                    state_d.pin   = host_wdata[2:0];
                    state_d.sel   = 1'b0;
                    state_d.avail = 1'b0;
                    state_d.ptr   = '0;
                    state_d.count = '0;
                    if (pin_hit) begin
                        state_d.phase  = PH_IDLE;
                        state_d.active = 1'b0;
                        state_d.hwrdy  = 1'b1;
                        state_d.waitf  = 1'b1;
                        state_d.port   = pin_port;
                        if (monitor_present[pin_port]) begin
                            state_d.avail = 1'b1;
                            state_d.terr  = 1'b0;
                        end else begin
                            state_d.terr  = 1'b1;
                        end
                    end
                end
                OFS_CMD: begin
                    if (state_q.cmd[CMD_SWCLR]) begin
                        if (!host_wdata[CMD_SWCLR]) begin
                            state_d.cmd[CMD_SWCLR] = 1'b0;
                            state_d.active = 1'b0;
                            state_d.terr   = !state_q.avail;
                            state_d.hwrdy  = 1'b1;
                            state_d.waitf  = 1'b0;
                            state_d.inuse  = 1'b0;
                            state_d.phase  = PH_IDLE;
                        end
                    end else begin
                        if (wv[CMD_SWCLR]) state_d.hwrdy = 1'b1;
                        state_d.count = wv[CMD_CNT_LO +: CMD_CNT_W];
                        if (wv[CMD_ADDR_LO +: 7] == EDID_ADDR) state_d.sel = 1'b1;
                        if (new_cyc[1]) state_d.ptr = PTR_W'(wv[CMD_IDX_LO +: 8]);
                        if (new_cyc == 3'd4) begin
                            if (old_cyc != 3'd0) begin
                                state_d.sel    = 1'b0;
                                state_d.avail  = 1'b0;
                                state_d.ptr    = '0;
                                state_d.count  = '0;
                                state_d.phase  = PH_IDLE;
                                state_d.active = 1'b0;
                            end
                        end else if (new_cyc[0]) begin
                            state_d.phase  = PH_DATA;
                            state_d.active = 1'b1;
                        end
                        state_d.cmd = wv;
                    end
                end
                OFS_STATUS: begin
                    if (host_wdata[ST_INUSE]) state_d.inuse = 1'b0;
                end
                default: ;
            endcase
        end

        if (host_rd) begin
            unique case (host_addr)
                OFS_PIN:    state_d.rdata = {29'b0, state_q.pin};
                OFS_CMD:    state_d.rdata = state_q.cmd;
                OFS_STATUS: begin
                    state_d.rdata = status_word;
                    state_d.inuse = 1'b1;
                end
                default: begin
                    if (state_q.cmd[CMD_DIR] && (left > 12'sd0)) begin
                        state_d.data  = 32'(packed_word);
                        state_d.rdata = 32'(packed_word);
                        state_d.ptr   = state_q.ptr + PTR_W'(take_n);
                        if (int'(left) <= LANES) begin
                            state_d.phase  = old_cyc[2] ? PH_IDLE : PH_WAIT;
                            state_d.active = 1'b0;
                            state_d.sel    = 1'b0;
                            state_d.avail  = 1'b0;
                            state_d.ptr    = '0;
                            state_d.count  = '0;
                        end
                    end else begin
                        state_d.rdata = state_q.data;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= '0;
            state_q.hwrdy  <= 1'b1;
            state_q.terr   <= 1'b1;
            state_q.phase  <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign host_rdata = state_q.rdata;

    // R8 / R7: the active flag tracks the data phase
    p_active_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.active == (state_q.phase == PH_DATA));

    // R9: a status read leaves in-use set
    p_inuse_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFS_STATUS) |=> state_q.inuse);

    // R9: writing one to in-use clears it
    p_inuse_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_STATUS && host_wdata[ST_INUSE]) |=> !state_q.inuse);

    // R2: a valid pin select leaves the bus ready and not active
    p_pin_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_PIN && pin_hit) |=>
            (state_q.hwrdy && state_q.waitf && !state_q.active && state_q.phase == PH_IDLE));

    // R6: a data read with nothing owed keeps the held word
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFS_DATA && left <= 12'sd0) |=>
            ($stable(state_q.data) && host_rdata == state_q.data));

    // R5: a full-width read advances the pointer by the lane count
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFS_DATA && state_q.cmd[CMD_DIR] && int'(left) > LANES) |=>
            (state_q.ptr == $past(state_q.ptr) + PTR_W'(LANES)));

    // R11: the software-ready bit never stays in the stored command
    p_swrdy_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFS_CMD) |=> !host_rdata[CMD_SWRDY]);

endmodule

// File: tb/tb_edid_reg_ctl.sv
module tb_edid_reg_ctl;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_PIN = 2'd0, A_CMD = 2'd1, A_ST = 2'd2, A_DAT = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  monitor_present = 4'b0101;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int checks = 0;
    int failures = 0;

    edid_reg_ctl dut (
        .clk(clk), .rst_n(rst_n), .monitor_present(monitor_present),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] tbyte(input int k);
        if (k >= 128) return 8'h00;
        return 8'((29 * k + 60) % 256);
    endfunction

    function automatic logic [31:0] st(input int act, input int terr, input int hw,
                                       input int wt, input int inu, input int ph);
        return 32'(act + terr*2 + hw*4 + wt*8 + inu*16 + ph*64);
    endfunction

    function automatic logic [31:0] mkcmd(input int dir, input int adr, input int idx,
                                          input int cnt, input int cyc);
        return 32'(dir) | (32'(adr) << 1) | (32'(idx) << 8) | (32'(cnt) << 16) | (32'(cyc) << 25);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    // status read followed by an in-use clear, so the next read starts clean
    task automatic rd_st(output logic [31:0] d);
        rd(A_ST, d);
        wr(A_ST, 32'h10);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] v, held, cmdv;
        int starts[4];
        starts = '{0, 5, 120, 126};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_st(v);      check("R1 status", v, 32'h06);
        rd(A_CMD, v);  check("R1 command", v, 32'h0);
        rd(A_DAT, v);  check("R1 data", v, 32'h0);

        // R2 pin to port without monitor (pin 2 -> port 1)
        wr(A_PIN, 32'd2);
        rd_st(v);      check("R2 absent monitor", v, st(0,1,1,1,0,0));
        wr(A_PIN, 32'd0);
        rd_st(v);      check("R2 pin zero", v, st(0,1,1,1,0,0));
        wr(A_PIN, 32'd5);
        rd_st(v);      check("R2 pin five", v, st(0,1,1,1,0,0));
        rd(A_PIN, v);  check("R2 pin readback", v, 32'd5);
        wr(A_PIN, 32'd1);
        rd_st(v);      check("R2 present monitor", v, st(0,0,1,1,0,0));

        // R4 other target address gives zero bytes
        wr(A_CMD, mkcmd(1, 7'h37, 0, 4, 5));
        rd(A_DAT, v);  check("R4 foreign address", v, 32'h0);
        rd_st(v);      check("R7 foreign completion", v, st(0,0,1,1,0,0));

        // R5 no monitor behind the port
        wr(A_PIN, 32'd2);
        wr(A_CMD, mkcmd(1, 7'h50, 0, 4, 5));
        rd(A_DAT, v);  check("R5 no monitor", v, 32'h0);

        // R3 index ignored without index bit
        wr(A_PIN, 32'd1);
        wr(A_CMD, mkcmd(1, 7'h50, 10, 4, 5));
        rd(A_DAT, v);
        held = {tbyte(3), tbyte(2), tbyte(1), tbyte(0)};
        check("R3 no index bit", v, held);

        // R12 held read data across a write
        wr(A_PIN, 32'd1);
        check("R12 rdata hold", host_rdata, held);

        // R6 read direction clear
        wr(A_CMD, mkcmd(0, 7'h50, 0, 8, 1));
        rd(A_DAT, v);  check("R6 write direction", v, held);
        rd_st(v);      check("R8 data phase", v, st(1,0,1,1,0,1));

        // R8 effective stop
        wr(A_CMD, mkcmd(1, 7'h50, 0, 8, 4));
        rd_st(v);      check("R8 stop idle", v, st(0,0,1,1,0,0));
        rd(A_DAT, v);  check("R8 stop reset count", v, held);

        // R8 stop ignored when stored cycle is zero
        wr(A_PIN, 32'd1);
        wr(A_CMD, mkcmd(1, 7'h50, 0, 8, 0));
        rd(A_DAT, v);  check("R8 cycle zero read", v, {tbyte(3), tbyte(2), tbyte(1), tbyte(0)});
        wr(A_CMD, mkcmd(1, 7'h50, 0, 8, 4));
        rd(A_DAT, v);  check("R8 ineffective stop", v, {tbyte(7), tbyte(6), tbyte(5), tbyte(4)});

        // R8 reserved cycle keeps phase
        wr(A_PIN, 32'd1);
        wr(A_CMD, mkcmd(1, 7'h50, 0, 8, 2));
        rd_st(v);      check("R8 reserved cycle", v, st(0,0,1,1,0,0));

        // R9 in-use behaviour
        rd(A_ST, v);   check("R9 first read", v, st(0,0,1,1,0,0));
        rd(A_ST, v);   check("R9 second read", v, st(0,0,1,1,1,0));
        wr(A_ST, 32'hEF);
        rd(A_ST, v);   check("R9 other bits ignored", v, st(0,0,1,1,1,0));
        wr(A_ST, 32'h10);
        rd(A_ST, v);   check("R9 cleared", v, st(0,0,1,1,0,0));
        wr(A_ST, 32'h10);

        // R10 / R11 software clear handshake
        wr(A_PIN, 32'd1);
        cmdv = mkcmd(1, 7'h50, 0, 8, 1) | 32'hC000_0000;
        wr(A_CMD, cmdv);
        rd_st(v);      check("R10 set phase", v, st(1,0,1,1,0,1));
        rd(A_CMD, v);  check("R11 ready bit cleared", v, cmdv & ~32'h4000_0000);
        wr(A_CMD, mkcmd(1, 7'h50, 3, 20, 5) | 32'h8000_0000);
        rd(A_CMD, v);  check("R10 ignored while set", v, cmdv & ~32'h4000_0000);
        wr(A_CMD, 32'h0);
        rd_st(v);      check("R10 reset with data", v, st(0,0,1,0,0,0));
        rd(A_CMD, v);  check("R10 bit cleared", v, cmdv & ~32'hC000_0000);
        wr(A_PIN, 32'd2);
        wr(A_CMD, 32'h8000_0000);
        wr(A_CMD, 32'h0);
        rd_st(v);      check("R10 reset without data", v, st(0,1,1,0,0,0));

        // R3 R5 R6 R7 sweep over start, length and completion type
        foreach (starts[si]) begin
            for (int len = 1; len <= 9; len++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    int s, cyc, k, rem, n;
                    logic [31:0] e;
                    s = starts[si];
                    cyc = (ci == 0) ? 3 : 7;
                    wr(A_PIN, 32'd1);
                    wr(A_CMD, mkcmd(1, 7'h50, s, s + len, cyc));
                    rd_st(v);  check("R8 sweep active", v, st(1,0,1,1,0,1));
                    k = s; rem = len; e = '0;
                    while (rem > 0) begin
                        n = (rem > 4) ? 4 : rem;
                        e = '0;
                        for (int i = 0; i < n; i++) e |= 32'(tbyte(k + i)) << (8 * i);
                        rd(A_DAT, v);
                        check("R5 sweep word", v, e);
                        k += n; rem -= n;
                    end
                    rd(A_DAT, v);  check("R6 sweep drained", v, e);
                    rd_st(v);
                    check("R7 sweep completion", v, (cyc == 7) ? st(0,0,1,1,0,0) : st(0,0,1,1,0,2));
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule